// File: doc/BRIEF.md
# Indexed video register port decoder

This block sits on the I/O side of a planar display adapter and terminates two indexed register banks: a sequencer bank and a graphics controller bank. Each bank is reached through a pair of byte addresses. The index port holds a selector. The data port stores nothing itself and opens onto whichever register that selector names. Software can set the selector and the selected register in one access by issuing a 16-bit write to the index port. The low byte becomes the selector and the high byte lands in the register that the new selector names.

The stored registers drive the decoded fields that the memory datapath uses: four plane write enables, the rotate count, the write mode and the bit mask. A parameter chooses whether the data and index ports can be read back. Without readback, every read sees a floating bus.

The request side is a valid/ready channel. `bus_ready` is held high, so the block never applies back-pressure. An access is taken in every cycle in which `bus_valid` is high. A write takes effect at that clock edge. Read data is combinational and is valid in the same cycle as the read request.

Top module: `vidreg_port_decoder`

## Requirements
- R1: Only the full 16-bit addresses 0x3C4 (sequencer index), 0x3C5 (sequencer data), 0x3CE (graphics index) and 0x3CF (graphics data) are decoded. A write to any other address changes nothing. A read of any other address returns 0xFF.
- R2: A 16-bit write (`bus_wide`=1) to an index port stores `bus_wdata[7:0]` in the index latch. If that new index is in range, the same clock edge also stores `bus_wdata[15:8]` in the register it names.
- R3: A byte write (`bus_wide`=0) to an index port updates only the index latch, and every stored register keeps its value.
- R4: A write to a data port stores `bus_wdata[7:0]` in the register named by the current index latch. The index latch keeps its value, and the high byte of a 16-bit data-port write is ignored.
- R5: The sequencer bank holds indices 0 to 4 and the graphics bank holds indices 0 to 8. A data write through an index beyond the bank changes no register. A data-port read through such an index returns 0x00.
- R6: After reset both index latches are 0. Every register is 0x00 except graphics index 8, which is 0xFF.
- R7: `plane_we` equals sequencer register 2 bits 3:0. `rotate_count` equals graphics register 3 bits 2:0. `write_mode` equals graphics register 5 bits 1:0. `bit_mask` equals graphics register 8.
- R8: With readback enabled (`READBACK`=1), an index-port read returns the index latch and a data-port read returns the selected register.
- R9: With readback disabled (`READBACK`=0), every read returns 0xFF, and writes behave exactly as with readback enabled.
- R10: `bus_ready` is always 1, and the state visible on the outputs changes only at the clock edge of an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Always high; the block never stalls |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit write, 0 = byte |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 16 | Write data; low byte first |
| bus_rdata | output | 8 | Read data, valid with a read request |
| plane_we | output | 4 | Plane write enables |
| rotate_count | output | 3 | Data rotate count |
| write_mode | output | 2 | Selected write mode |
| bit_mask | output | 8 | Bit mask |

## Verification
The hardest cases to reach from the ports are those where the index and the register change in the same edge. One is a 16-bit index write whose new selector differs from the old one, so the data must land at the new selector and not the old. The other is a data write made while the latch holds an index beyond the bank. The stimulus reaches both by first parking the latch with byte index writes at a known or out-of-range value. It then issues the wide or data-port write and reads back through the data port, while a behavioural model tracks every register. A second instance built without readback receives the same traffic, so its fields must match the model while all of its reads float.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;
  localparam logic [15:0] ADDR_SEQ_IDX = 16'h03C4;
  localparam logic [15:0] ADDR_SEQ_DAT = 16'h03C5;
  localparam logic [15:0] ADDR_GC_IDX  = 16'h03CE;
  localparam logic [15:0] ADDR_GC_DAT  = 16'h03CF;

  typedef enum logic [2:0] {
    PSEL_NONE,
    PSEL_SEQ_IDX,
    PSEL_SEQ_DAT,
    PSEL_GC_IDX,
    PSEL_GC_DAT
  } port_sel_e;

  function automatic port_sel_e decode_addr(input logic [15:0] a);
    case (a)
      ADDR_SEQ_IDX: return PSEL_SEQ_IDX;
      ADDR_SEQ_DAT: return PSEL_SEQ_DAT;
      ADDR_GC_IDX:  return PSEL_GC_IDX;
      ADDR_GC_DAT:  return PSEL_GC_DAT;
      default:      return PSEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vidreg_addr_decode.sv
module vidreg_addr_decode
  import vidreg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic          bus_wide,
  input  logic [AW-1:0] bus_addr,
  input  logic [2*DW-1:0] bus_wdata,
  output port_sel_e     sel,
  output logic          seq_idx_we,
  output logic          seq_dat_we,
  output logic          gc_idx_we,
  output logic          gc_dat_we,
  output logic [DW-1:0] idx_wdata,
  output logic [DW-1:0] dat_wdata
);
  logic wr;
  logic wide_idx;

  always_comb begin
    sel       = decode_addr(16'(bus_addr));
    wr        = bus_valid && bus_write;
    wide_idx  = wr && bus_wide && (sel == PSEL_SEQ_IDX || sel == PSEL_GC_IDX);
    idx_wdata = bus_wdata[DW-1:0];
    // data byte: high half when it rides on an index write, else low half
    dat_wdata = wide_idx ? bus_wdata[2*DW-1:DW] : bus_wdata[DW-1:0];
    seq_idx_we = wr && sel == PSEL_SEQ_IDX;
    gc_idx_we  = wr && sel == PSEL_GC_IDX;
    seq_dat_we = wr && (sel == PSEL_SEQ_DAT || (bus_wide && sel == PSEL_SEQ_IDX));
    gc_dat_we  = wr && (sel == PSEL_GC_DAT || (bus_wide && sel == PSEL_GC_IDX));
  end
endmodule

// File: rtl/vidreg_bank.sv
module vidreg_bank #(
  parameter int NREGS    = 9,
  parameter int MASK_IDX = -1,
  parameter int DW       = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      idx_we,
  input  logic [DW-1:0]             idx_wdata,
  input  logic                      dat_we,
  input  logic [DW-1:0]             dat_wdata,
  output logic [DW-1:0]             idx_q,
  output logic [DW-1:0]             rd_data,
  output logic [NREGS-1:0][DW-1:0]  regs_q
);
  localparam int SELW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [DW-1:0] LIMIT = DW'(NREGS);

  logic [DW-1:0] target;
  logic          tgt_ok;
  logic          cur_ok;

  always_comb begin
    target = idx_we ? idx_wdata : idx_q;
    tgt_ok = target < LIMIT;
    cur_ok = idx_q < LIMIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= idx_wdata;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [DW-1:0] RST = (g == MASK_IDX) ? {DW{1'b1}} : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= RST;
      else if (dat_we && tgt_ok && target == DW'(g))
        regs_q[g] <= dat_wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++)
      if (cur_ok && idx_q == DW'(i)) rd_data = regs_q[i];
  end

  p_index_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && !dat_we) |=> $stable(regs_q));

  p_wide_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && dat_we && idx_wdata < LIMIT) |=>
      (idx_q == $past(idx_wdata) &&
       regs_q[$past(idx_wdata[SELW-1:0])] == $past(dat_wdata)));

  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_we && dat_we && idx_q < LIMIT) |=>
      ($stable(idx_q) && regs_q[$past(idx_q[SELW-1:0])] == $past(dat_wdata)));

  p_out_of_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !(target < LIMIT)) |=> $stable(regs_q));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_we && !dat_we) |=> ($stable(regs_q) && $stable(idx_q)));
endmodule

// File: rtl/vidreg_port_decoder.sv
module vidreg_port_decoder
  import vidreg_pkg::*;
#(
  parameter bit READBACK = 1'b1,
  parameter int SEQ_REGS = 5,
  parameter int GC_REGS  = 9,
  parameter int DW       = 8,
  parameter int AW       = 16,
  parameter int PLANES   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic            bus_wide,
  input  logic [AW-1:0]   bus_addr,
  input  logic [2*DW-1:0] bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [PLANES-1:0] plane_we,
  output logic [2:0]      rotate_count,
  output logic [1:0]      write_mode,
  output logic [DW-1:0]   bit_mask
);
  localparam int IDX_MAP_MASK = 2;
  localparam int IDX_ROTATE   = 3;
  localparam int IDX_MODE     = 5;
  localparam int IDX_BIT_MASK = 8;
  localparam logic [DW-1:0] FLOAT = {DW{1'b1}};

  port_sel_e sel;
  logic seq_idx_we, seq_dat_we, gc_idx_we, gc_dat_we;
  logic [DW-1:0] idx_wdata, dat_wdata;
  logic [DW-1:0] seq_idx, gc_idx, seq_rd, gc_rd;
  logic [SEQ_REGS-1:0][DW-1:0] seq_regs;
  logic [GC_REGS-1:0][DW-1:0]  gc_regs;

  assign bus_ready = 1'b1;

  vidreg_addr_decode #(.AW(AW), .DW(DW)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sel(sel),
    .seq_idx_we(seq_idx_we), .seq_dat_we(seq_dat_we),
    .gc_idx_we(gc_idx_we), .gc_dat_we(gc_dat_we),
    .idx_wdata(idx_wdata), .dat_wdata(dat_wdata)
  );

  vidreg_bank #(.NREGS(SEQ_REGS), .MASK_IDX(-1), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .idx_we(seq_idx_we), .idx_wdata(idx_wdata),
    .dat_we(seq_dat_we), .dat_wdata(dat_wdata), .idx_q(seq_idx),
    .rd_data(seq_rd), .regs_q(seq_regs)
  );

  vidreg_bank #(.NREGS(GC_REGS), .MASK_IDX(IDX_BIT_MASK), .DW(DW)) u_gc (
    .clk(clk), .rst_n(rst_n), .idx_we(gc_idx_we), .idx_wdata(idx_wdata),
    .dat_we(gc_dat_we), .dat_wdata(dat_wdata), .idx_q(gc_idx),
    .rd_data(gc_rd), .regs_q(gc_regs)
  );

  always_comb begin
    plane_we     = seq_regs[IDX_MAP_MASK][PLANES-1:0];
    rotate_count = gc_regs[IDX_ROTATE][2:0];
    write_mode   = gc_regs[IDX_MODE][1:0];
    bit_mask     = gc_regs[IDX_BIT_MASK];
  end

  if (READBACK) begin : g_rb
    always_comb begin
      case (sel)
        PSEL_SEQ_IDX: bus_rdata = seq_idx;
        PSEL_SEQ_DAT: bus_rdata = seq_rd;
        PSEL_GC_IDX:  bus_rdata = gc_idx;
        PSEL_GC_DAT:  bus_rdata = gc_rd;
        default:      bus_rdata = FLOAT;
      endcase
    end
  end else begin : g_wo
    assign bus_rdata = FLOAT;
  end

  p_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!READBACK && bus_valid && !bus_write) |-> bus_rdata == FLOAT);

  p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == PSEL_NONE) |=> ($stable(seq_regs) && $stable(gc_regs) &&
                            $stable(seq_idx) && $stable(gc_idx)));
endmodule

// File: tb/vidreg_port_decoder_bench.sv
module vidreg_port_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSEQ = 5;
  localparam int NGC  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [15:0] bus_addr = 16'h0, bus_wdata = 16'h0;
  logic bus_ready, bus_ready_wo;
  logic [7:0] rdata, rdata_wo, bit_mask, bit_mask_wo;
  logic [3:0] plane_we, plane_we_wo;
  logic [2:0] rotate_count, rotate_count_wo;
  logic [1:0] write_mode, write_mode_wo;

  int checks = 0, fails = 0;
  bit running = 1'b0;
  int m_seq [NSEQ];
  int m_gc  [NGC];
  int m_sidx, m_gidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidreg_port_decoder #(.READBACK(1'b1)) u_vidreg_port_decoder (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .plane_we(plane_we),
    .rotate_count(rotate_count), .write_mode(write_mode), .bit_mask(bit_mask));

  vidreg_port_decoder #(.READBACK(1'b0)) u_vidreg_port_decoder_wo (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready_wo),
    .bus_write(bus_write), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_wo), .plane_we(plane_we_wo),
    .rotate_count(rotate_count_wo), .write_mode(write_mode_wo), .bit_mask(bit_mask_wo));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sidx = 0; m_gidx = 0;
    foreach (m_seq[i]) m_seq[i] = 0;
    foreach (m_gc[i]) m_gc[i] = 0;
    m_gc[8] = 'hFF;
  endtask

  // per-clock comparison of the decoded fields against the model
  always @(negedge clk) if (running) begin
    check("R7 plane_we", int'(plane_we), m_seq[2] & 'hF);
    check("R7 rotate_count", int'(rotate_count), m_gc[3] & 7);
    check("R7 write_mode", int'(write_mode), m_gc[5] & 3);
    check("R7 bit_mask", int'(bit_mask), m_gc[8]);
    check("R9 wo fields", {int'(plane_we_wo), int'(rotate_count_wo), int'(write_mode_wo), int'(bit_mask_wo)},
          {m_seq[2] & 'hF, m_gc[3] & 7, m_gc[5] & 3, m_gc[8]});
    check("R10 ready", int'(bus_ready & bus_ready_wo), 1);
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input bit wide);
    int lo, hi;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    lo = int'(d[7:0]); hi = int'(d[15:8]);
    case (a)
      16'h03C4: begin m_sidx = lo; if (wide && lo < NSEQ) m_seq[lo] = hi; end
      16'h03CE: begin m_gidx = lo; if (wide && lo < NGC) m_gc[lo] = hi; end
      16'h03C5: if (m_sidx < NSEQ) m_seq[m_sidx] = lo;
      16'h03CF: if (m_gidx < NGC) m_gc[m_gidx] = lo;
      default: ;
    endcase
    #1 bus_valid = 0; bus_write = 0; bus_wide = 0;
  endtask

  task automatic rd(input string req, input logic [15:0] a);
    int exp;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_wide = 0; bus_addr = a;
    case (a)
      16'h03C4: exp = m_sidx;
      16'h03CE: exp = m_gidx;
      16'h03C5: exp = (m_sidx < NSEQ) ? m_seq[m_sidx] : 0;
      16'h03CF: exp = (m_gidx < NGC) ? m_gc[m_gidx] : 0;
      default:  exp = 'hFF;
    endcase
    #1;
    check(req, int'(rdata), exp);
    check("R9 wo read", int'(rdata_wo), 'hFF);
    @(posedge clk);
    #1 bus_valid = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    running = 1'b1;
    // R6 reset state
    rd("R6 seq index reset", 16'h03C4);
    rd("R6 gc index reset", 16'h03CE);
    rd("R6 gc reg0 reset", 16'h03CF);
    wr(16'h03CE, 16'h0008, 0);
    rd("R6 bit mask reset", 16'h03CF);
    // R2 wide index writes
    wr(16'h03C4, 16'h0F02, 1);
    rd("R2 map mask via data", 16'h03C5);
    wr(16'h03CE, 16'h0003, 1);
    wr(16'h03CE, 16'h0205, 1);
    rd("R2 mode reg", 16'h03CF);
    // R3 byte index write leaves registers alone
    wr(16'h03CE, 16'h7708, 0);
    rd("R3 bit mask untouched", 16'h03CF);
    rd("R8 index readback", 16'h03CE);
    // R4 data port window
    wr(16'h03CF, 16'hAA55, 0);
    rd("R4 bit mask written", 16'h03CF);
    rd("R4 index unchanged", 16'h03CE);
    wr(16'h03CE, 16'h0703, 1);
    wr(16'h03C5, 16'hAB0C, 1);
    rd("R4 wide data low byte", 16'h03C5);
    // R5 out of range
    wr(16'h03CE, 16'h0009, 0);
    wr(16'h03CF, 16'h0077, 0);
    rd("R5 gc out of range read", 16'h03CF);
    wr(16'h03C4, 16'h3305, 1);
    rd("R5 seq out of range read", 16'h03C5);
    rd("R8 out of range index", 16'h03C4);
    wr(16'h03C4, 16'h9904, 1);
    rd("R5 seq top index", 16'h03C5);
    // R1 unmapped and aliased addresses
    wr(16'h03C6, 16'hFFFF, 1);
    wr(16'h13C4, 16'h0102, 1);
    wr(16'h03CD, 16'h0000, 0);
    rd("R1 unmapped read", 16'h03C6);
    rd("R1 alias read", 16'h13CF);
    rd("R1 seq index after alias", 16'h03C4);
    // sweep all graphics registers
    for (int i = 0; i < NGC; i++) wr(16'h03CE, {8'(i * 17 + 1), 8'(i)}, 1);
    for (int i = 0; i < NGC; i++) begin
      wr(16'h03CE, 16'(i), 0);
      rd("R8 gc sweep", 16'h03CF);
    end
    for (int i = 0; i < NSEQ; i++) begin
      wr(16'h03C4, 16'(i), 0);
      wr(16'h03C5, 16'(8'hA0 + i), 0);
      rd("R4 seq sweep", 16'h03C5);
    end
    @(negedge clk);
    running = 1'b0;
    report();
  end
endmodule